// File: doc/BRIEF.md
# Sign/Magnitude Current-DAC Control Slave (I2C)

This block is the digital front end of a four-channel current DAC whose outputs can either sink or source. It is a slave on an I2C bus. SCL and SDA are oversampled on a system clock, and SDA is driven open-drain: the block only ever pulls the line low. A host sets a channel by writing one control byte, and it can read that byte back using a repeated START. Each channel drives three registered outputs: a source flag, a sink flag and a magnitude.

The 7-bit bus address is not fixed. It comes from two address-select inputs, and each input has three states (low, high, floating). Together they choose one of nine addresses. The select pins also serve as an emergency bus reset: any change on them drops the transfer in progress and releases SDA. The analog sensing of the pins and the current generation are outside this block.

Top module: `idac_i2c_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, every source and sink flag is 0, every magnitude is 0, and `sda_oe_o` is 0. All control bytes start at 00h.
- R2: Each select input is coded 00 = tied low, 01 = tied high, 10 or 11 = floating. The pair gives address index k, and the device address is 48h + k. For (sel1,sel0) the index is: (low,low)=0, (low,high)=1, (high,low)=2, (high,high)=3, (float,low)=4, (float,high)=5, (low,float)=6, (high,float)=7, (float,float)=8.
- R3: The write sequence is START, address byte with bit 0 = 0, pointer byte, data byte, STOP. It stores the data byte in the channel the pointer selects: F8h is channel 0, F9h channel 1, FAh channel 2 and FBh channel 3. Bit 7 of the byte is the direction (1 = source, 0 = sink), and bits 4:0 are the magnitude that appears on `ch_mag_o[5*i +: 5]`. Outputs change only while SCL is low.
- R4: A channel whose magnitude is 0 shows both flags low, whatever its direction bit holds. The source and sink flags of a channel are never high together.
- R5: A read is START, address/write, pointer, repeated START, address with bit 0 = 1, then 8 bits driven MSB first. The read returns {direction, 0, 0, magnitude}, so bits 6:5 always read back as zero.
- R6: If an address byte does not match, it is not acknowledged, and nothing is acknowledged or stored until the next START.
- R7: A pointer outside F8h..FBh is acknowledged, but the data byte that follows changes no channel. A read through such a pointer returns 00h.
- R8: A change on either select input releases `sda_oe_o` within two clock cycles and returns the slave to idle. A data byte that was not yet complete at that moment is not acknowledged and not stored.
- R9: For every accepted byte the host writes, the slave holds SDA low through the ninth SCL pulse. It asserts SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| sel1_i | input | 2 | Upper address-select state (00 low, 01 high, 1x floating) |
| sel0_i | input | 2 | Lower address-select state (00 low, 01 high, 1x floating) |
| ch_source_o | output | 4 | Per-channel source flag |
| ch_sink_o | output | 4 | Per-channel sink flag |
| ch_mag_o | output | 20 | Per-channel 5-bit magnitude, channel i at [5*i +: 5] |

## Verification
A wrong internal state shows up at the ports within the next byte. If the shift register or the bit count is wrong, an ACK lands in the wrong slot or goes missing. If the pointer is wrong, a different channel output changes after the data byte, about four system clocks after that byte's eighth falling SCL edge. If the stored byte is wrong, it shows on the channel flags at once and again on read-back through the repeated-START path. A slave that does not return to idle after an abort or after a mismatched address shows up as an ACK that should not be there on the very next byte.

// File: rtl/idac_pkg.sv
package idac_pkg;

  typedef enum logic [1:0] {
    TL_LOW   = 2'b00,
    TL_HIGH  = 2'b01,
    TL_FLOAT = 2'b10
  } trilvl_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_SKIP
  } bus_st_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_PTR,
    K_DATA,
    K_DONE
  } byte_kind_e;

  localparam logic [6:0] DEV_BASE = 7'h48;

  function automatic logic [3:0] sel_index(input logic [1:0] s1, input logic [1:0] s0);
    logic f1, f0;
    f1 = s1[1];
    f0 = s0[1];
    if (f1 && f0)      sel_index = 4'd8;
    else if (f1)       sel_index = 4'd4 + {3'b000, s0[0]};
    else if (f0)       sel_index = 4'd6 + {3'b000, s1[0]};
    else               sel_index = {2'b00, s1[0], s0[0]};
  endfunction

endpackage

// File: rtl/idac_sync.sv
module idac_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/idac_addr_sel.sv
module idac_addr_sel
  import idac_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel1,
  input  logic [1:0] sel0,
  output logic [6:0] dev_addr,
  output logic       abort
);
  logic [3:0] sel_q;

  always_ff @(posedge clk) begin
    sel_q <= {sel1, sel0};
  end

  always_ff @(posedge clk) begin
    if (rst) dev_addr <= DEV_BASE + {3'b000, sel_index(sel1, sel0)};
    else     dev_addr <= DEV_BASE + {3'b000, sel_index(sel1, sel0)};
  end

  assign abort = ~rst & ({sel1, sel0} != sel_q);
endmodule

// File: rtl/idac_i2c_engine.sv
module idac_i2c_engine
  import idac_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_lvl,
  input  logic       sda_rise,
  input  logic       sda_fall,
  input  logic [6:0] dev_addr,
  input  logic       abort,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] ptr,
  output logic [7:0] wr_data
);
  bus_st_e    st;
  byte_kind_e kind;
  logic [7:0] sh;
  logic [7:0] tx_sh;
  logic [3:0] cnt;
  logic       rd_mode;
  logic       start_c, stop_c;

  assign start_c = scl_lvl & sda_fall;
  assign stop_c  = scl_lvl & sda_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      kind    <= K_DEV;
      sh      <= '0;
      tx_sh   <= '0;
      cnt     <= '0;
      rd_mode <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      ptr     <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (abort) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_c) begin
        st     <= S_RX;
        kind   <= K_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_lvl};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              case (kind)
                K_DEV: begin
                  if (sh[7:1] == dev_addr) begin
                    sda_oe  <= 1'b1;
                    st      <= S_ACK;
                    rd_mode <= sh[0];
                    kind    <= K_PTR;
                    tx_sh   <= rd_data;
                  end else begin
                    st <= S_SKIP;
                  end
                end
                K_PTR: begin
                  ptr     <= sh;
                  sda_oe  <= 1'b1;
                  st      <= S_ACK;
                  rd_mode <= 1'b0;
                  kind    <= K_DATA;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_data <= sh;
                  sda_oe  <= 1'b1;
                  st      <= S_ACK;
                  rd_mode <= 1'b0;
                  kind    <= K_DONE;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                sda_oe <= ~tx_sh[7];
                tx_sh  <= {tx_sh[6:0], 1'b0};
                cnt    <= 4'd1;
                st     <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= (kind == K_DONE) ? S_SKIP : S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= S_SKIP;
              end else begin
                sda_oe <= ~tx_sh[7];
                tx_sh  <= {tx_sh[6:0], 1'b0};
                cnt    <= cnt + 4'd1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/idac_chan_regs.sv
module idac_chan_regs #(
  parameter int NCH = 4,
  parameter int MAG_W = 5,
  parameter logic [7:0] REG_BASE = 8'hF8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [7:0]         ptr,
  input  logic [7:0]         wr_data,
  output logic [7:0]         rd_data,
  output logic [NCH-1:0]     ch_source,
  output logic [NCH-1:0]     ch_sink,
  output logic [NCH*MAG_W-1:0] ch_mag
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [8:0] TOP_EXCL = 9'(REG_BASE) + 9'(NCH);

  logic [NCH-1:0]   sgn;
  logic [MAG_W-1:0] mag [NCH];
  logic             hit;
  logic [7:0]       offs;
  logic [IDX_W-1:0] idx;
  logic             unused_rsv;

  assign hit  = ({1'b0, ptr} >= 9'(REG_BASE)) && ({1'b0, ptr} < TOP_EXCL);
  assign offs = ptr - REG_BASE;
  assign idx  = offs[IDX_W-1:0];
  assign unused_rsv = ^{wr_data[6:MAG_W], offs};

  always_ff @(posedge clk) begin
    if (rst) begin
      sgn <= '0;
      for (int i = 0; i < NCH; i++) mag[i] <= '0;
    end else if (wr_en && hit) begin
      sgn[idx] <= wr_data[7];
      mag[idx] <= wr_data[MAG_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (hit) begin
      rd_data[7]         = sgn[idx];
      rd_data[MAG_W-1:0] = mag[idx];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) begin
        ch_source[g]               <= 1'b0;
        ch_sink[g]                 <= 1'b0;
        ch_mag[g*MAG_W +: MAG_W]   <= '0;
      end else begin
        ch_source[g]               <= sgn[g] & (|mag[g]);
        ch_sink[g]                 <= ~sgn[g] & (|mag[g]);
        ch_mag[g*MAG_W +: MAG_W]   <= mag[g];
      end
    end
  end
endmodule

// File: rtl/idac_i2c_ctrl.sv
module idac_i2c_ctrl #(
  parameter int NCH = 4,
  parameter int MAG_W = 5,
  parameter logic [7:0] REG_BASE = 8'hF8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic [1:0]           sel1_i,
  input  logic [1:0]           sel0_i,
  output logic [NCH-1:0]       ch_source_o,
  output logic [NCH-1:0]       ch_sink_o,
  output logic [NCH*MAG_W-1:0] ch_mag_o
);
  logic       scl_lvl, scl_rise, scl_fall;
  logic       sda_lvl, sda_rise, sda_fall;
  logic [6:0] dev_addr;
  logic       abort;
  logic       wr_en;
  logic [7:0] ptr, wr_data, rd_data;

  idac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst(rst), .din(scl_i),
    .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall)
  );

  idac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst(rst), .din(sda_i),
    .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall)
  );

  idac_addr_sel u_addr (
    .clk(clk), .rst(rst), .sel1(sel1_i), .sel0(sel0_i),
    .dev_addr(dev_addr), .abort(abort)
  );

  idac_i2c_engine u_eng (
    .clk(clk), .rst(rst),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .dev_addr(dev_addr), .abort(abort), .rd_data(rd_data),
    .sda_oe(sda_oe_o), .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data)
  );

  idac_chan_regs #(.NCH(NCH), .MAG_W(MAG_W), .REG_BASE(REG_BASE)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data),
    .rd_data(rd_data), .ch_source(ch_source_o), .ch_sink(ch_sink_o),
    .ch_mag(ch_mag_o)
  );
endmodule

// File: rtl/idac_i2c_ctrl_chk.sv
module idac_i2c_ctrl_chk #(
  parameter int NCH = 4,
  parameter int MAG_W = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 scl_i,
  input logic                 sda_oe_o,
  input logic [1:0]           sel1_i,
  input logic [1:0]           sel0_i,
  input logic [NCH-1:0]       ch_source_o,
  input logic [NCH-1:0]       ch_sink_o,
  input logic [NCH*MAG_W-1:0] ch_mag_o
);
  logic [NCH-1:0] zmask;

  for (genvar g = 0; g < NCH; g++) begin : g_z
    assign zmask[g] = (ch_mag_o[g*MAG_W +: MAG_W] == '0);
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (ch_source_o == '0 && ch_sink_o == '0 && ch_mag_o == '0 && !sda_oe_o));

  a_r4_zero_mag_silent: assert property (@(posedge clk) disable iff (rst)
    ((ch_source_o | ch_sink_o) & zmask) == '0);

  a_r4_one_direction: assert property (@(posedge clk) disable iff (rst)
    (ch_source_o & ch_sink_o) == '0);

  a_r8_abort_release: assert property (@(posedge clk) disable iff (rst)
    !$stable({sel1_i, sel0_i}) |=> !sda_oe_o);

  a_r9_drive_in_low_phase: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_i);

  a_r3_update_in_low_phase: assert property (@(posedge clk) disable iff (rst)
    !$stable({ch_source_o, ch_sink_o, ch_mag_o}) |-> !scl_i);
endmodule

bind idac_i2c_ctrl idac_i2c_ctrl_chk #(.NCH(NCH), .MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .sel1_i(sel1_i), .sel0_i(sel0_i), .ch_source_o(ch_source_o),
  .ch_sink_o(ch_sink_o), .ch_mag_o(ch_mag_o)
);

// File: tb/tb_idac_i2c_ctrl.sv
module tb_idac_i2c_ctrl;
  localparam int NCH = 4;
  localparam int MAG_W = 5;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic [1:0] sel1 = 2'b10;
  logic [1:0] sel0 = 2'b10;
  logic sda_oe;
  logic sda_line;
  logic [NCH-1:0] src, snk;
  logic [NCH*MAG_W-1:0] mag;

  int total = 0;
  int bad = 0;
  string tag_q[$];
  int    val_q[$];
  int    obs_val;
  event  obs_ev;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  idac_i2c_ctrl dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .sel1_i(sel1), .sel0_i(sel0), .ch_source_o(src), .ch_sink_o(snk),
    .ch_mag_o(mag)
  );

  // scoreboard monitor
  initial begin
    forever begin
      @(obs_ev);
      total++;
      if (tag_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected result actual=%0h expected=none", obs_val);
      end else begin
        automatic string t = tag_q.pop_front();
        automatic int    v = val_q.pop_front();
        if (obs_val !== v) begin
          bad++;
          $display("FAIL %s actual=%0h expected=%0h", t, obs_val, v);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string t, int exp_v, int act_v);
    tag_q.push_back(t);
    val_q.push_back(exp_v);
    obs_val = act_v;
    ->obs_ev;
    @(negedge clk);
  endtask

  function automatic int pack(int i);
    return {25'd0, src[i], snk[i], mag[i*MAG_W +: MAG_W]};
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2 * Q);
  endtask

  task automatic send_bits(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      scl = 1'b1; tick(2 * Q);
      scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    send_bits(b);
    m_sda = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    ack = sda_line;
    tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl = 1'b0; tick(2 * Q);
    end
    m_sda = 1'b1;
    scl = 1'b1; tick(2 * Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic wr_reg(logic [6:0] dev, logic [7:0] ptr, logic [7:0] d, string t);
    logic a;
    bus_start();
    send_byte({dev, 1'b0}, a); chk({t, " R9 dev ack"}, 0, a);
    send_byte(ptr, a);         chk({t, " R9 ptr ack"}, 0, a);
    send_byte(d, a);           chk({t, " R9 data ack"}, 0, a);
    bus_stop();
    tick(4);
  endtask

  task automatic rd_reg(logic [6:0] dev, logic [7:0] ptr, int exp_v, string t);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte({dev, 1'b0}, a); chk({t, " R9 dev ack"}, 0, a);
    send_byte(ptr, a);         chk({t, " R9 ptr ack"}, 0, a);
    bus_rstart();
    send_byte({dev, 1'b1}, a); chk({t, " R5 read addr ack"}, 0, a);
    recv_byte(b);              chk(t, exp_v, b);
    bus_stop();
    tick(4);
  endtask

  task automatic set_sel(int k);
    case (k)
      0: begin sel1 = 2'b00; sel0 = 2'b00; end
      1: begin sel1 = 2'b00; sel0 = 2'b01; end
      2: begin sel1 = 2'b01; sel0 = 2'b00; end
      3: begin sel1 = 2'b01; sel0 = 2'b01; end
      4: begin sel1 = 2'b10; sel0 = 2'b00; end
      5: begin sel1 = 2'b10; sel0 = 2'b01; end
      6: begin sel1 = 2'b00; sel0 = 2'b10; end
      7: begin sel1 = 2'b01; sel0 = 2'b10; end
      default: begin sel1 = 2'b10; sel0 = 2'b10; end
    endcase
    tick(4);
  endtask

  initial begin
    logic a;
    tick(5);
    rst = 1'b0;
    tick(3);

    // R1 reset state
    chk("R1 sda released", 0, sda_oe);
    for (int i = 0; i < NCH; i++) chk("R1 channel zero", 0, pack(i));

    // R3 writes with default (float,float) -> 50h
    wr_reg(7'h50, 8'hF8, 8'h92, "R3 ch0");
    chk("R3 ch0 source 12h", 7'h52, pack(0));
    wr_reg(7'h50, 8'hF9, 8'h05, "R3 ch1");
    chk("R3 ch1 sink 05h", 7'h25, pack(1));
    wr_reg(7'h50, 8'hFB, 8'hFF, "R3 ch3");
    chk("R3 ch3 source 1Fh", 7'h5F, pack(3));
    chk("R3 ch0 untouched", 7'h52, pack(0));

    // R4 zero magnitude
    wr_reg(7'h50, 8'hFA, 8'h83, "R4 ch2");
    chk("R4 ch2 source 3", 7'h43, pack(2));
    wr_reg(7'h50, 8'hFA, 8'h80, "R4 ch2");
    chk("R4 zero mag with sign set", 0, pack(2));

    // R5 read back
    rd_reg(7'h50, 8'hF8, 8'h92, "R5 read ch0");
    rd_reg(7'h50, 8'hF9, 8'h05, "R5 read ch1");
    rd_reg(7'h50, 8'hFB, 8'h9F, "R5 reserved bits zero");
    rd_reg(7'h50, 8'hFA, 8'h80, "R5 read ch2 sign only");

    // R7 out of range pointer
    wr_reg(7'h50, 8'hF7, 8'h11, "R7 ptr F7");
    wr_reg(7'h50, 8'hFC, 8'h1E, "R7 ptr FC");
    chk("R7 ch0 unchanged", 7'h52, pack(0));
    chk("R7 ch1 unchanged", 7'h25, pack(1));
    chk("R7 ch2 unchanged", 0, pack(2));
    chk("R7 ch3 unchanged", 7'h5F, pack(3));
    rd_reg(7'h50, 8'hF7, 0, "R7 read outside");

    // R6 mismatched address
    bus_start();
    send_byte({7'h49, 1'b0}, a); chk("R6 no ack wrong addr", 1, a);
    send_byte(8'hF8, a);         chk("R6 no ack ptr", 1, a);
    send_byte(8'h00, a);         chk("R6 no ack data", 1, a);
    bus_stop();
    tick(4);
    chk("R6 ch0 unchanged", 7'h52, pack(0));
    rd_reg(7'h50, 8'hF8, 8'h92, "R6 ch0 readback");

    // R2 address sweep
    for (int k = 0; k < 9; k++) begin
      set_sel(k);
      bus_start();
      send_byte({7'(7'h48 + k), 1'b0}, a); chk("R2 decoded addr ack", 0, a);
      bus_stop();
      tick(4);
      bus_start();
      send_byte({7'(7'h48 + ((k + 1) % 9)), 1'b0}, a); chk("R2 neighbour nack", 1, a);
      bus_stop();
      tick(4);
    end

    // R8 abort during pointer ACK
    set_sel(8);
    bus_start();
    send_byte({7'h50, 1'b0}, a); chk("R8 pre dev ack", 0, a);
    send_bits(8'hF9);
    m_sda = 1'b1; tick(Q);
    chk("R9 ack driven in low phase", 1, sda_oe);
    sel1 = 2'b00; sel0 = 2'b00;
    tick(3);
    chk("R8 sda released", 0, sda_oe);
    scl = 1'b1; tick(2 * Q);
    scl = 1'b0; tick(Q);
    send_byte(8'h1A, a); chk("R8 idle after abort", 1, a);
    bus_stop();
    tick(4);
    chk("R8 ch1 unchanged", 7'h25, pack(1));
    rd_reg(7'h48, 8'hF9, 8'h05, "R8 ch1 readback");

    tick(20);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule